// File: doc/BRIEF.md
# Address monitor and wait controller

This block sits beside a core's execution pipeline and supports monitor/wait style instructions. An arm request names a physical address, which of three arming flavours issued it (plain, extended or user-level), an extension operand and a flag saying whether the target memory is write-back. A wait request names one of four wait flavours and carries a hint word. The block either puts the core into a sleep state or lets the wait complete at once. A snoop port reports every store seen by the coherence fabric as a start address and a byte length. A store that overlaps the watched line wakes the core, tears down the monitor and pulses a request to cancel any wake-up timer.

The controller is a three-state machine: ACTIVE, SLEEP (ended by an unmasked interrupt or a hit) and SLEEP_ANYIRQ (ended by any interrupt, even a masked one, or a hit). Its transitions are named ENTER_SLEEP and ENTER_SLEEP_ANYIRQ (ACTIVE to a sleep state on a successful wait), WAKE_HIT (either sleep state to ACTIVE on a snoop hit) and WAKE_IRQ (either sleep state to ACTIVE on an interrupt). All outputs are registered and change at the edge after the request.

Top module: `mwait_ctrl`

## Requirements
- R1: After reset the state is ACTIVE (act_state = 0), fault and timer_cancel are low and no arm is held, so any checked wait completes at once.
- R2: With an arm held at address A and line size L (default 64), a store at begin B of length N is a hit unless B >= A+L-1 or B+N <= A. A store starting at A+L-1 is therefore a miss.
- R3: An accepted arm records its flavour (arm_kind 0 plain, 1 extended, 2 user) and replaces any earlier arm. arm_kind 3 arms nothing. A wait of flavour wait_kind 0, 1 or 2 sleeps only if the held arm has the same code; otherwise it completes at once.
- R4: A plain or extended arm with a nonzero extension operand raises fault one cycle later and leaves the held arm unchanged. A user arm ignores the operand.
- R5: An arm with arm_wb low raises no fault and leaves the held arm unchanged.
- R6: A wait faults (one-cycle fault pulse, no sleep) when hint bits above bit 0 are set for wait_kind 0, 2 or 3, or when hint bits above bit 1 are set for wait_kind 1.
- R7: A sleeping plain or extended wait enters SLEEP_ANYIRQ (act_state = 2) when hint bit 0 is set and SLEEP (act_state = 1) otherwise. User and paused waits always enter SLEEP_ANYIRQ.
- R8: A snoop hit while armed pulses timer_cancel for one cycle, clears the arm, and returns either sleep state to ACTIVE.
- R9: A paused wait (wait_kind 3) does not need an arm to sleep. A fault-free paused wait clears a held user-level arm and leaves other arms intact.
- R10: SLEEP ends on irq with irq_masked low. SLEEP_ANYIRQ ends on irq regardless of irq_masked. Either wake clears the arm.
- R11: Arm and wait requests presented while in a sleep state are ignored: no fault, no arm change, no state change.
- R12: When a request and a snoop hit fall in the same cycle, the hit clears the old arm first. A wait in that cycle stays ACTIVE, and an arm in that cycle is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_valid | input | 1 | Arm request strobe |
| arm_kind | input | 2 | Arming flavour: 0 plain, 1 extended, 2 user, 3 none |
| arm_addr | input | ADDR_W | Physical address to watch |
| arm_opnd | input | OPND_W | Extension operand, must be zero for plain/extended |
| arm_wb | input | 1 | Target memory type is write-back |
| wait_valid | input | 1 | Wait request strobe |
| wait_kind | input | 2 | Wait flavour: 0 plain, 1 extended, 2 user, 3 paused |
| wait_hint | input | OPND_W | Hint word |
| snoop_valid | input | 1 | Observed store strobe |
| snoop_addr | input | ADDR_W | Store start address |
| snoop_len | input | LEN_W | Store length in bytes |
| irq | input | 1 | Interrupt pending |
| irq_masked | input | 1 | Pending interrupt is masked |
| act_state | output | 2 | 0 ACTIVE, 1 SLEEP, 2 SLEEP_ANYIRQ |
| fault | output | 1 | One-cycle general-protection fault pulse |
| timer_cancel | output | 1 | One-cycle wake-up timer cancel pulse |

## Verification
The interesting collision is a snoop hit landing in the same cycle as a wait or arm request. The wait has just checked an arm that the hit is tearing down, and a new arm must survive the clear aimed at the old one. The bench provokes both cases by driving the request and a store to the armed line on the same clock. It then judges the outcome at the ports: the core stays ACTIVE with a cancel pulse, and a follow-up wait and store show which arm survived. A behavioural reference model tracks state, arm flavour and address and is compared with every output on every clock.

// File: rtl/mwc_pkg.sv
package mwc_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE    = 2'd0,
        ST_SLEEP     = 2'd1,
        ST_SLEEP_ANY = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        ARM_PLAIN = 2'd0,
        ARM_EXT   = 2'd1,
        ARM_USER  = 2'd2,
        ARM_NONE  = 2'd3
    } arm_kind_e;

    typedef enum logic [1:0] {
        WT_PLAIN = 2'd0,
        WT_EXT   = 2'd1,
        WT_USER  = 2'd2,
        WT_PAUSE = 2'd3
    } wait_kind_e;

endpackage

// File: rtl/mwc_range_match.sv
module mwc_range_match #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int LEN_W      = 8
) (
    input  logic              armed,
    input  logic [ADDR_W-1:0] base,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [LEN_W-1:0]  snp_len,
    output logic              hit
);
    localparam int SUM_W = ADDR_W + 1;
    localparam logic [SUM_W-1:0] LINE_M1 = SUM_W'(LINE_BYTES - 1);

    logic [SUM_W-1:0] lo;
    logic [SUM_W-1:0] lim;
    logic [SUM_W-1:0] st;
    logic [SUM_W-1:0] en;
    logic             above;
    logic             below;

    always_comb begin
        lo    = {1'b0, base};
        lim   = lo + LINE_M1;
        st    = {1'b0, snp_addr};
        en    = st + {{(SUM_W-LEN_W){1'b0}}, snp_len};
        // Start at or past the last byte, or end at or before the line start
        above = (st >= lim);
        below = (en <= lo);
        hit   = armed & snp_valid & ~(above | below);
    end
endmodule

// File: rtl/mwc_arm_track.sv
module mwc_arm_track
    import mwc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OPND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        kind_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [OPND_W-1:0] opnd_in,
    input  logic              wb_in,
    input  logic              clear,
    output logic              opnd_fault,
    output arm_kind_e         held_kind,
    output logic [ADDR_W-1:0] held_addr
);
    arm_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    arm_kind_e         req_kind;
    logic              checks_opnd;
    logic              accept;

    always_comb begin
        req_kind    = arm_kind_e'(kind_in);
        checks_opnd = (req_kind == ARM_PLAIN) || (req_kind == ARM_EXT);
        opnd_fault  = req & checks_opnd & (|opnd_in);
        accept      = req & (req_kind != ARM_NONE) & ~opnd_fault & wb_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= ARM_NONE;
            addr_q <= '0;
        end else if (accept) begin
            kind_q <= req_kind;
            addr_q <= addr_in;
        end else if (clear) begin
            kind_q <= ARM_NONE;
        end
    end

    assign held_kind = kind_q;
    assign held_addr = addr_q;
endmodule

// File: rtl/mwc_wait_decode.sv
module mwc_wait_decode
    import mwc_pkg::*;
#(
    parameter int OPND_W = 32
) (
    input  logic [1:0]        kind_in,
    input  logic [OPND_W-1:0] hint,
    input  arm_kind_e         held_kind,
    output logic              hint_fault,
    output logic              arm_match,
    output logic              clr_user,
    output act_e              target
);
    wait_kind_e wk;

    always_comb begin
        wk         = wait_kind_e'(kind_in);
        hint_fault = 1'b0;
        arm_match  = 1'b0;
        target     = ST_SLEEP_ANY;
        unique case (wk)
            WT_PLAIN: begin
                hint_fault = |hint[OPND_W-1:1];
                arm_match  = (held_kind == ARM_PLAIN);
                target     = hint[0] ? ST_SLEEP_ANY : ST_SLEEP;
            end
            WT_EXT: begin
                hint_fault = |hint[OPND_W-1:2];
                arm_match  = (held_kind == ARM_EXT);
                target     = hint[0] ? ST_SLEEP_ANY : ST_SLEEP;
            end
            WT_USER: begin
                hint_fault = |hint[OPND_W-1:1];
                arm_match  = (held_kind == ARM_USER);
            end
            WT_PAUSE: begin
                hint_fault = |hint[OPND_W-1:1];
                arm_match  = 1'b1;
            end
        endcase
        clr_user = (wk == WT_PAUSE) & ~hint_fault & (held_kind == ARM_USER);
    end
endmodule

// File: rtl/mwait_ctrl.sv
module mwait_ctrl
    import mwc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int LEN_W      = 8,
    parameter int OPND_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_valid,
    input  logic [1:0]        arm_kind,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic [OPND_W-1:0] arm_opnd,
    input  logic              arm_wb,
    input  logic              wait_valid,
    input  logic [1:0]        wait_kind,
    input  logic [OPND_W-1:0] wait_hint,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [LEN_W-1:0]  snoop_len,
    input  logic              irq,
    input  logic              irq_masked,
    output logic [1:0]        act_state,
    output logic              fault,
    output logic              timer_cancel
);
    act_e              st_q;
    act_e              st_d;
    logic              awake;
    logic              arm_req;
    logic              wait_req;
    logic              hit;
    logic              wake_irq;
    logic              arm_clear;
    logic              opnd_fault;
    logic              hint_fault;
    logic              arm_match;
    logic              clr_user;
    act_e              target;
    arm_kind_e         held_kind;
    logic [ADDR_W-1:0] held_addr;
    logic              fault_q;
    logic              cancel_q;

    // Requests are only taken while the core runs
    assign awake    = (st_q == ST_ACTIVE);
    assign arm_req  = arm_valid & awake;
    assign wait_req = wait_valid & awake;

    mwc_arm_track #(
        .ADDR_W (ADDR_W),
        .OPND_W (OPND_W)
    ) u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (arm_req),
        .kind_in    (arm_kind),
        .addr_in    (arm_addr),
        .opnd_in    (arm_opnd),
        .wb_in      (arm_wb),
        .clear      (arm_clear),
        .opnd_fault (opnd_fault),
        .held_kind  (held_kind),
        .held_addr  (held_addr)
    );

    mwc_range_match #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .LEN_W      (LEN_W)
    ) u_match (
        .armed     (held_kind != ARM_NONE),
        .base      (held_addr),
        .snp_valid (snoop_valid),
        .snp_addr  (snoop_addr),
        .snp_len   (snoop_len),
        .hit       (hit)
    );

    mwc_wait_decode #(
        .OPND_W (OPND_W)
    ) u_dec (
        .kind_in    (wait_kind),
        .hint       (wait_hint),
        .held_kind  (held_kind),
        .hint_fault (hint_fault),
        .arm_match  (arm_match),
        .clr_user   (clr_user),
        .target     (target)
    );

    always_comb begin
        wake_irq  = ((st_q == ST_SLEEP) & irq & ~irq_masked) |
                    ((st_q == ST_SLEEP_ANY) & irq);
        arm_clear = hit | wake_irq | (wait_req & clr_user);
    end

    // Next-state logic: ENTER_SLEEP / ENTER_SLEEP_ANYIRQ / WAKE_HIT / WAKE_IRQ
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ACTIVE: begin
                if (wait_req && !hint_fault && arm_match && !hit)
                    st_d = target;
            end
            ST_SLEEP, ST_SLEEP_ANY: begin
                if (hit || wake_irq)
                    st_d = ST_ACTIVE;
            end
            default: st_d = ST_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_ACTIVE;
        else
            st_q <= st_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q  <= 1'b0;
            cancel_q <= 1'b0;
        end else begin
            fault_q  <= opnd_fault | (wait_req & hint_fault);
            cancel_q <= hit;
        end
    end

    assign act_state    = st_q;
    assign fault        = fault_q;
    assign timer_cancel = cancel_q;
endmodule

// File: rtl/mwc_chk.sv
module mwc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wait_valid,
    input logic       snoop_valid,
    input logic       irq,
    input logic [1:0] act_state,
    input logic       fault,
    input logic       timer_cancel
);
    // R1
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_state != 2'd3);

    // R8
    cancel_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_cancel |-> act_state == 2'd0);

    // R6
    fault_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> act_state == 2'd0);

    // R7
    sleep_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_state == 2'd0 && !wait_valid) |=> act_state == 2'd0);

    // R10
    anyirq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_state == 2'd2 && irq) |=> act_state == 2'd0);

    // R11
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_state != 2'd0 && !irq && !snoop_valid) |=> act_state == $past(act_state));
endmodule

bind mwait_ctrl mwc_chk u_mwc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wait_valid   (wait_valid),
    .snoop_valid  (snoop_valid),
    .irq          (irq),
    .act_state    (act_state),
    .fault        (fault),
    .timer_cancel (timer_cancel)
);

// File: tb/test_mwait_ctrl.sv
module test_mwait_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int ADDR_W = 32;
    localparam int LINE   = 64;
    localparam int LEN_W  = 8;
    localparam int OPND_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arm_valid = 1'b0;
    logic [1:0]        arm_kind = '0;
    logic [ADDR_W-1:0] arm_addr = '0;
    logic [OPND_W-1:0] arm_opnd = '0;
    logic              arm_wb = 1'b1;
    logic              wait_valid = 1'b0;
    logic [1:0]        wait_kind = '0;
    logic [OPND_W-1:0] wait_hint = '0;
    logic              snoop_valid = 1'b0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic [LEN_W-1:0]  snoop_len = '0;
    logic              irq = 1'b0;
    logic              irq_masked = 1'b0;
    logic [1:0]        act_state;
    logic              fault;
    logic              timer_cancel;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // reference model state
    int     m_state = 0;
    int     m_kind  = 3;
    longint m_addr  = 0;
    int     e_fault = 0;
    int     e_cancel = 0;

    always #2.5 clk = ~clk;

    mwait_ctrl #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE), .LEN_W(LEN_W), .OPND_W(OPND_W)
    ) i_mwait_ctrl (
        .clk(clk), .rst_n(rst_n),
        .arm_valid(arm_valid), .arm_kind(arm_kind), .arm_addr(arm_addr),
        .arm_opnd(arm_opnd), .arm_wb(arm_wb),
        .wait_valid(wait_valid), .wait_kind(wait_kind), .wait_hint(wait_hint),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_len(snoop_len),
        .irq(irq), .irq_masked(irq_masked),
        .act_state(act_state), .fault(fault), .timer_cancel(timer_cancel)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit     active, av, wv, hit, wake, afault, aacc, hf, match;
        int     tgt, nstate, nkind;
        longint sa, se;
        active = (m_state == 0);
        av = arm_valid && active;
        wv = wait_valid && active;
        sa = longint'(snoop_addr);
        se = sa + longint'(snoop_len);
        hit = (m_kind != 3) && snoop_valid && !(sa >= m_addr + LINE - 1 || se <= m_addr);
        wake = (m_state == 1 && irq && !irq_masked) || (m_state == 2 && irq);
        afault = av && (arm_kind < 2) && (arm_opnd != 0);
        aacc = av && (arm_kind != 3) && !afault && arm_wb;
        hf = (wait_kind == 1) ? ((wait_hint >> 2) != 0) : ((wait_hint >> 1) != 0);
        case (wait_kind)
            2'd0: match = (m_kind == 0);
            2'd1: match = (m_kind == 1);
            2'd2: match = (m_kind == 2);
            default: match = 1'b1;
        endcase
        tgt = (wait_kind >= 2 || wait_hint[0]) ? 2 : 1;
        if (active) nstate = (wv && !hf && match && !hit) ? tgt : 0;
        else        nstate = (hit || wake) ? 0 : m_state;
        if (aacc) begin
            nkind = int'(arm_kind);
            m_addr = longint'(arm_addr);
        end else if (hit || wake || (wv && !hf && wait_kind == 3 && m_kind == 2))
            nkind = 3;
        else
            nkind = m_kind;
        m_state  = nstate;
        m_kind   = nkind;
        e_fault  = (afault || (wv && hf)) ? 1 : 0;
        e_cancel = hit ? 1 : 0;
    endtask

    // one clock: model at the edge, compare at the following falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(cur_req, "act_state", int'(act_state), m_state);
        check(cur_req, "fault", int'(fault), e_fault);
        check(cur_req, "timer_cancel", int'(timer_cancel), e_cancel);
        arm_valid = 1'b0; wait_valid = 1'b0; snoop_valid = 1'b0; irq = 1'b0;
        irq_masked = 1'b0; arm_opnd = '0; arm_wb = 1'b1; wait_hint = '0;
    endtask

    task automatic set_arm(int k, longint a, int op, bit wb);
        arm_valid = 1'b1; arm_kind = 2'(k); arm_addr = ADDR_W'(a);
        arm_opnd = OPND_W'(op); arm_wb = wb;
    endtask

    task automatic set_wait(int k, int h);
        wait_valid = 1'b1; wait_kind = 2'(k); wait_hint = OPND_W'(h);
    endtask

    task automatic set_snoop(longint a, int n);
        snoop_valid = 1'b1; snoop_addr = ADDR_W'(a); snoop_len = LEN_W'(n);
    endtask

    task automatic do_arm(int k, longint a, int op, bit wb);
        set_arm(k, a, op, wb); tick();
    endtask

    task automatic do_wait(int k, int h);
        set_wait(k, h); tick();
    endtask

    task automatic do_snoop(longint a, int n);
        set_snoop(a, n); tick();
    endtask

    task automatic do_irq(bit masked);
        irq = 1'b1; irq_masked = masked; tick();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset act_state", int'(act_state), 0);
        check("R1", "reset fault", int'(fault), 0);
        check("R1", "reset timer_cancel", int'(timer_cancel), 0);
        rst_n = 1'b1;
        cur_req = "R1";
        do_wait(0, 0);
        check("R1", "no arm after reset, wait stays active", int'(act_state), 0);

        // R3: flavour matching
        cur_req = "R3";
        do_arm(0, 32'h1000, 0, 1'b1);
        do_wait(1, 0);
        do_wait(2, 0);
        check("R3", "mismatched waits stay active", int'(act_state), 0);
        do_wait(0, 0);
        check("R3", "matching plain wait sleeps", int'(act_state), 1);

        // R10: masked irq does not end SLEEP, unmasked does and disarms
        cur_req = "R10";
        do_irq(1'b1);
        check("R10", "masked irq keeps SLEEP", int'(act_state), 1);
        do_irq(1'b0);
        check("R10", "unmasked irq wakes", int'(act_state), 0);
        do_wait(0, 0);
        check("R10", "irq wake cleared arm", int'(act_state), 0);

        // R4: operand fault
        cur_req = "R4";
        do_arm(1, 32'h1000, 5, 1'b1);
        check("R4", "ext arm operand fault", int'(fault), 1);
        do_wait(1, 0);
        check("R4", "faulted arm not held", int'(act_state), 0);
        do_arm(2, 32'h1800, 5, 1'b1);
        check("R4", "user arm ignores operand", int'(fault), 0);
        do_wait(2, 0);
        check("R4", "user arm held", int'(act_state), 2);
        do_irq(1'b1);

        // R5: non write-back
        cur_req = "R5";
        do_arm(1, 32'h1000, 0, 1'b0);
        check("R5", "non-wb no fault", int'(fault), 0);
        do_wait(1, 0);
        check("R5", "non-wb not armed", int'(act_state), 0);

        // R6: hint faults
        cur_req = "R6";
        do_arm(1, 32'h1000, 0, 1'b1);
        do_wait(1, 4);
        check("R6", "ext wait bit2 faults", int'(fault), 1);
        do_wait(0, 2);
        check("R6", "plain wait bit1 faults", int'(fault), 1);
        do_wait(1, 2);
        check("R6", "ext wait bit1 allowed", int'(act_state), 1);

        // R8: hit wakes with cancel
        cur_req = "R8";
        do_snoop(32'h1020, 4);
        check("R8", "hit cancel pulse", int'(timer_cancel), 1);
        check("R8", "hit wakes", int'(act_state), 0);
        tick();
        check("R8", "cancel one cycle", int'(timer_cancel), 0);

        // R2: boundaries
        cur_req = "R2";
        do_arm(0, 32'h2000, 0, 1'b1);
        do_snoop(32'h203F, 1);
        check("R2", "start at last byte misses", int'(timer_cancel), 0);
        do_snoop(32'h1FFC, 4);
        check("R2", "end at line start misses", int'(timer_cancel), 0);
        do_snoop(32'h1FFC, 5);
        check("R2", "one byte overlap hits", int'(timer_cancel), 1);
        do_arm(0, 32'h2000, 0, 1'b1);
        do_snoop(32'h203E, 1);
        check("R2", "second-last byte hits", int'(timer_cancel), 1);
        do_snoop(32'h2000, 1);
        check("R2", "disarmed no hit", int'(timer_cancel), 0);

        // R7: sleep variants
        cur_req = "R7";
        do_arm(0, 32'h2000, 0, 1'b1);
        do_wait(0, 1);
        check("R7", "hint0 gives SLEEP_ANYIRQ", int'(act_state), 2);
        do_irq(1'b1);
        check("R7", "masked irq ends SLEEP_ANYIRQ", int'(act_state), 0);
        do_arm(2, 32'h2000, 0, 1'b1);
        do_wait(2, 0);
        check("R7", "user wait gives SLEEP_ANYIRQ", int'(act_state), 2);

        // R11: requests ignored while asleep
        cur_req = "R11";
        do_arm(0, 32'h9000, 0, 1'b1);
        do_arm(1, 32'h9000, 7, 1'b1);
        check("R11", "no fault while asleep", int'(fault), 0);
        do_wait(1, 8);
        check("R11", "no hint fault while asleep", int'(fault), 0);
        do_snoop(32'h9000, 4);
        check("R11", "ignored arm not watched", int'(act_state), 2);
        do_snoop(32'h2010, 2);
        check("R11", "old arm still wakes", int'(act_state), 0);

        // R9: paused wait
        cur_req = "R9";
        do_wait(3, 0);
        check("R9", "pause sleeps without arm", int'(act_state), 2);
        do_irq(1'b0);
        do_arm(2, 32'h3000, 0, 1'b1);
        do_wait(3, 2);
        check("R9", "pause hint fault", int'(fault), 1);
        do_wait(3, 0);
        do_snoop(32'h3000, 4);
        check("R9", "pause cleared user arm", int'(timer_cancel), 0);
        check("R9", "still asleep", int'(act_state), 2);
        do_irq(1'b0);
        do_arm(0, 32'h3000, 0, 1'b1);
        do_wait(3, 0);
        do_snoop(32'h3000, 4);
        check("R9", "pause keeps plain arm", int'(timer_cancel), 1);

        // R12: same-cycle collisions
        cur_req = "R12";
        do_arm(0, 32'h4000, 0, 1'b1);
        set_wait(0, 0); set_snoop(32'h4000, 4); tick();
        check("R12", "wait with hit stays active", int'(act_state), 0);
        check("R12", "wait with hit cancels", int'(timer_cancel), 1);
        do_arm(0, 32'h4000, 0, 1'b1);
        set_arm(1, 32'h5000, 0, 1'b1); set_snoop(32'h4000, 4); tick();
        do_wait(1, 0);
        check("R12", "arm with hit kept", int'(act_state), 1);
        do_snoop(32'h5000, 8);
        check("R12", "kept arm wakes", int'(act_state), 0);
        tick();

        finish_run();
    end
endmodule